// File: doc/BRIEF.md
# AUX Chunked Native Transfer Sequencer

This block runs native read and write transfers of any length over a DisplayPort AUX request engine. A host asks for a transfer at a 20-bit target address with a byte count. The sequencer splits the transfer into chunks of at most sixteen bytes. For each chunk it programs the split address, a command word and the engine's data buffer, starts the engine, and waits first for the enable flag to self-clear and then for a reply. It then checks the error flag and the reply status, and retries a failed chunk up to a fixed number of attempts.

Host data sits in a byte buffer owned by the host. The sequencer reads write data from it and writes read data into it through an index, a write strobe and two data buses. The AUX PHY and the engine itself are outside the block and appear only as flags, strobes and a small indexed data buffer. Both timeouts are counted in clock cycles from a clock-rate parameter.

Top module: `aux_xfer_seq`

## Requirements
- R1: A transfer of L bytes is issued as ceil(L/16) chunks in address order. Every chunk carries 16 bytes except the last, which carries the remainder (1 to 16 bytes).
- R2: Each chunk is attempted at most 10 times. If the tenth attempt fails, the transfer ends with `done_o` and `err_o` high together, and no further engine start follows.
- R3: While a chunk is issued, the engine sees the 20-bit target address as `eng_addr_lo_o` = bits 7:0, `eng_addr_mid_o` = bits 15:8 and `eng_addr_hi_o` = bits 19:16. Address arithmetic wraps modulo 2^20.
- R4: The command word has bits 7:4 = chunk length minus one and bit 3 = 1 (native transaction; 0 would select I2C). Bit 2 is 0, bit 1 is 0, and bit 0 = 1 for a read or 0 for a write.
- R5: Every attempt begins with a one-cycle `eng_buf_clr_o`. For a write, engine buffer slots 0..n-1 are then loaded with host bytes at the chunk's data offset, before `eng_start_o`.
- R6: After `eng_start_o`, if `eng_en_i` is still high after CLK_KHZ*20 cycles (20 ms), the attempt fails.
- R7: After `eng_en_i` clears, if `eng_reply_i` is not seen within CLK_KHZ*10 cycles (10 ms), the attempt fails. A seen reply is acknowledged with `eng_reply_ack_o` in the same cycle.
- R8: An attempt fails if `eng_err_i` is high after the reply, or if `eng_status_i` is nonzero. The error flag is acknowledged with `eng_err_ack_o` when seen.
- R9: The address and the host data offset advance by the chunk length only after a clean attempt. Read data is written into the host buffer (index = offset + slot) only after a clean reply, exactly once per byte.
- R10: `busy_o` is high from the cycle after an accepted request until the transfer ends. `done_o` is a one-cycle pulse at the end. Requests that arrive while busy are ignored.
- R11: A zero-length request starts no engine access. It gives a `done_o` pulse with `err_o` low in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Transfer request, sampled when idle |
| wr_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 20 | Target start address |
| len_i | input | LEN_W (9) | Byte count |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | End-of-transfer pulse |
| err_o | output | 1 | Transfer failed, valid with done_o |
| hbuf_idx_o | output | IDX_W (8) | Host buffer byte index |
| hbuf_rdata_i | input | 8 | Host byte at hbuf_idx_o |
| hbuf_we_o | output | 1 | Host buffer write strobe |
| hbuf_wdata_o | output | 8 | Read byte to host |
| eng_addr_lo_o | output | 8 | Address bits 7:0 |
| eng_addr_mid_o | output | 8 | Address bits 15:8 |
| eng_addr_hi_o | output | 4 | Address bits 19:16 |
| eng_cmd_o | output | 8 | Command word |
| eng_buf_clr_o | output | 1 | Clear engine data buffer |
| eng_buf_we_o | output | 1 | Engine buffer write strobe |
| eng_buf_idx_o | output | 4 | Engine buffer slot |
| eng_buf_wdata_o | output | 8 | Byte into engine buffer |
| eng_buf_rdata_i | input | 8 | Engine buffer byte at slot |
| eng_start_o | output | 1 | Set engine enable (pulse) |
| eng_en_i | input | 1 | Engine enable flag readback |
| eng_reply_i | input | 1 | Reply-received flag |
| eng_reply_ack_o | output | 1 | Clear reply flag |
| eng_err_i | input | 1 | Access error flag |
| eng_err_ack_o | output | 1 | Clear error flag |
| eng_status_i | input | 4 | Reply status, 0 = clean |

## Verification
Some rules are checked on every cycle: acknowledges only toward a raised flag, a native command on every start, buffer loads only right after a clear, the done pulse shape with error never without done, and silence at both buffers while idle. Chunk sizes, address splitting and wrap, the retry limit, both timeouts and the exact bytes moved in each direction can only be shown by the bench. Its reference model follows every start and every host write, while a scripted engine model produces each failure kind in turn.

// File: rtl/aux_seq_pkg.sv
package aux_seq_pkg;
  localparam int unsigned ADDR_W    = 20;
  localparam int unsigned CHUNK_MAX = 16;
  localparam int unsigned CHUNK_W   = 5;
  localparam int unsigned SLOT_W    = 4;
  localparam int unsigned STAT_W    = 4;

  typedef enum logic [3:0] {
    S_IDLE, S_CLR, S_LOAD, S_ISSUE, S_WEN, S_WRP, S_CHK, S_FAIL, S_COPY, S_ADV
  } seq_state_e;

  // [7:4] len-1, [3] native, [2:1] zero, [0] read
  function automatic logic [7:0] make_cmd(input logic rd, input logic [CHUNK_W-1:0] n);
    logic [CHUNK_W-1:0] m;
    m = n - CHUNK_W'(1);
    return {m[3:0], 1'b1, 2'b00, rd};
  endfunction
endpackage

// File: rtl/aux_seq_ptrs.sv
module aux_seq_ptrs
  import aux_seq_pkg::*;
#(
  parameter int unsigned LEN_W = 9,
  parameter int unsigned IDX_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                load_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [LEN_W-1:0]    len_i,
  input  logic                adv_i,
  output logic [ADDR_W-1:0]   addr_o,
  output logic [IDX_W-1:0]    off_o,
  output logic [CHUNK_W-1:0]  chunk_o,
  output logic                last_o
);
  logic [LEN_W-1:0] rem_q;

  assign last_o  = rem_q <= LEN_W'(CHUNK_MAX);
  assign chunk_o = last_o ? CHUNK_W'(rem_q) : CHUNK_W'(CHUNK_MAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o <= '0;
      off_o  <= '0;
      rem_q  <= '0;
    end else if (load_i) begin
      addr_o <= addr_i;
      off_o  <= '0;
      rem_q  <= len_i;
    end else if (adv_i) begin
      addr_o <= addr_o + ADDR_W'(chunk_o);
      off_o  <= off_o + IDX_W'(chunk_o);
      rem_q  <= rem_q - LEN_W'(chunk_o);
    end
  end
endmodule

// File: rtl/aux_seq_timer.sv
module aux_seq_timer #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic [CNT_W-1:0] lim_i,
  output logic             exp_o
);
  logic [CNT_W-1:0] cnt_q;

  assign exp_o = cnt_q >= lim_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (!exp_o) cnt_q <= cnt_q + CNT_W'(1);
  end
endmodule

// File: rtl/aux_seq_retry.sv
module aux_seq_retry #(
  parameter int unsigned TRIES = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  output logic last_o
);
  localparam int unsigned RW = $clog2(TRIES + 1);
  logic [RW-1:0] cnt_q;

  assign last_o = cnt_q == RW'(TRIES - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (inc_i) cnt_q <= cnt_q + RW'(1);
  end
endmodule

// File: rtl/aux_xfer_seq.sv
module aux_xfer_seq
  import aux_seq_pkg::*;
#(
  parameter int unsigned MAX_LEN = 256,
  parameter int unsigned TRIES   = 10,
  parameter int unsigned CLK_KHZ = 250000,
  parameter int unsigned EN_MS   = 20,
  parameter int unsigned RP_MS   = 10,
  localparam int unsigned LEN_W  = $clog2(MAX_LEN + 1),
  localparam int unsigned IDX_W  = $clog2(MAX_LEN)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic               wr_i,
  input  logic [19:0]        addr_i,
  input  logic [LEN_W-1:0]   len_i,
  output logic               busy_o,
  output logic               done_o,
  output logic               err_o,
  output logic [IDX_W-1:0]   hbuf_idx_o,
  input  logic [7:0]         hbuf_rdata_i,
  output logic               hbuf_we_o,
  output logic [7:0]         hbuf_wdata_o,
  output logic [7:0]         eng_addr_lo_o,
  output logic [7:0]         eng_addr_mid_o,
  output logic [3:0]         eng_addr_hi_o,
  output logic [7:0]         eng_cmd_o,
  output logic               eng_buf_clr_o,
  output logic               eng_buf_we_o,
  output logic [3:0]         eng_buf_idx_o,
  output logic [7:0]         eng_buf_wdata_o,
  input  logic [7:0]         eng_buf_rdata_i,
  output logic               eng_start_o,
  input  logic               eng_en_i,
  input  logic               eng_reply_i,
  output logic               eng_reply_ack_o,
  input  logic               eng_err_i,
  output logic               eng_err_ack_o,
  input  logic [3:0]         eng_status_i
);
  localparam int unsigned CNT_W  = 32;
  localparam logic [CNT_W-1:0] EN_LIM = CNT_W'(CLK_KHZ * EN_MS);
  localparam logic [CNT_W-1:0] RP_LIM = CNT_W'(CLK_KHZ * RP_MS);

  seq_state_e          state_q, state_d;
  logic [SLOT_W-1:0]   bidx_q, bidx_d;
  logic                wr_q, done_q, done_d, err_q, err_d;
  logic                ptr_load, ptr_adv, ptr_last;
  logic [ADDR_W-1:0]   cur_addr;
  logic [IDX_W-1:0]    cur_off;
  logic [CHUNK_W-1:0]  chunk;
  logic                rt_clr, rt_inc, rt_last;
  logic                tmr_clr, tmr_exp;
  logic                slot_last;

  aux_seq_ptrs #(.LEN_W(LEN_W), .IDX_W(IDX_W)) u_ptrs (
    .clk_i, .rst_ni,
    .load_i (ptr_load), .addr_i, .len_i, .adv_i (ptr_adv),
    .addr_o (cur_addr), .off_o (cur_off), .chunk_o (chunk), .last_o (ptr_last)
  );

  aux_seq_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk_i, .rst_ni, .clr_i (tmr_clr),
    .lim_i (state_q == S_WRP ? RP_LIM : EN_LIM), .exp_o (tmr_exp)
  );

  aux_seq_retry #(.TRIES(TRIES)) u_retry (
    .clk_i, .rst_ni, .clr_i (rt_clr), .inc_i (rt_inc), .last_o (rt_last)
  );

  assign slot_last = CHUNK_W'(bidx_q) == chunk - CHUNK_W'(1);
  // timer restarts on entry to each wait phase
  assign tmr_clr = !(state_q == S_WEN || state_q == S_WRP) ||
                   (state_q == S_WEN && !eng_en_i);

  assign busy_o          = state_q != S_IDLE;
  assign done_o          = done_q;
  assign err_o           = err_q;
  assign eng_addr_lo_o   = cur_addr[7:0];
  assign eng_addr_mid_o  = cur_addr[15:8];
  assign eng_addr_hi_o   = cur_addr[19:16];
  assign eng_cmd_o       = make_cmd(!wr_q, chunk);
  assign eng_buf_idx_o   = bidx_q;
  assign eng_buf_wdata_o = hbuf_rdata_i;
  assign hbuf_wdata_o    = eng_buf_rdata_i;
  assign hbuf_idx_o      = cur_off + IDX_W'(bidx_q);

  always_comb begin
    state_d         = state_q;
    bidx_d          = bidx_q;
    done_d          = 1'b0;
    err_d           = 1'b0;
    ptr_load        = 1'b0;
    ptr_adv         = 1'b0;
    rt_clr          = 1'b0;
    rt_inc          = 1'b0;
    eng_buf_clr_o   = 1'b0;
    eng_buf_we_o    = 1'b0;
    eng_start_o     = 1'b0;
    eng_reply_ack_o = 1'b0;
    eng_err_ack_o   = 1'b0;
    hbuf_we_o       = 1'b0;
    unique case (state_q)
      S_IDLE: if (req_i) begin
        if (len_i == '0) done_d = 1'b1;
        else begin
          ptr_load = 1'b1;
          rt_clr   = 1'b1;
          state_d  = S_CLR;
        end
      end
      S_CLR: begin
        eng_buf_clr_o = 1'b1;
        bidx_d        = '0;
        state_d       = wr_q ? S_LOAD : S_ISSUE;
      end
      S_LOAD: begin
        eng_buf_we_o = 1'b1;
        bidx_d       = bidx_q + SLOT_W'(1);
        if (slot_last) state_d = S_ISSUE;
      end
      S_ISSUE: begin
        eng_start_o = 1'b1;
        state_d     = S_WEN;
      end
      S_WEN: begin
        if (!eng_en_i)    state_d = S_WRP;
        else if (tmr_exp) state_d = S_FAIL;
      end
      S_WRP: begin
        if (eng_reply_i) begin
          eng_reply_ack_o = 1'b1;
          state_d         = S_CHK;
        end else if (tmr_exp) state_d = S_FAIL;
      end
      S_CHK: begin
        if (eng_err_i) begin
          eng_err_ack_o = 1'b1;
          state_d       = S_FAIL;
        end else if (eng_status_i != '0) state_d = S_FAIL;
        else begin
          bidx_d  = '0;
          state_d = wr_q ? S_ADV : S_COPY;
        end
      end
      S_FAIL: begin
        if (rt_last) begin
          done_d  = 1'b1;
          err_d   = 1'b1;
          state_d = S_IDLE;
        end else begin
          rt_inc  = 1'b1;
          state_d = S_CLR;
        end
      end
      S_COPY: begin
        hbuf_we_o = 1'b1;
        bidx_d    = bidx_q + SLOT_W'(1);
        if (slot_last) state_d = S_ADV;
      end
      S_ADV: begin
        ptr_adv = 1'b1;
        rt_clr  = 1'b1;
        if (ptr_last) begin
          done_d  = 1'b1;
          state_d = S_IDLE;
        end else state_d = S_CLR;
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      bidx_q  <= '0;
      wr_q    <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      bidx_q  <= bidx_d;
      done_q  <= done_d;
      err_q   <= err_d;
      if (ptr_load) wr_q <= wr_i;
    end
  end
endmodule

// File: rtl/aux_xfer_seq_chk.sv
module aux_xfer_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       busy_o,
  input logic       done_o,
  input logic       err_o,
  input logic       hbuf_we_o,
  input logic [7:0] eng_cmd_o,
  input logic       eng_buf_clr_o,
  input logic       eng_buf_we_o,
  input logic       eng_start_o,
  input logic       eng_reply_i,
  input logic       eng_reply_ack_o,
  input logic       eng_err_i,
  input logic       eng_err_ack_o
);
  a_r4_native_cmd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_start_o |-> eng_cmd_o[3] && eng_cmd_o[2:1] == 2'b00);

  a_r5_load_after_clr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(eng_buf_we_o) |-> $past(eng_buf_clr_o));

  a_r7_ack_needs_reply: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_reply_ack_o |-> eng_reply_i);

  a_r8_ack_needs_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_err_ack_o |-> eng_err_i);

  a_r9_copy_apart_from_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hbuf_we_o |-> !eng_buf_we_o && !eng_start_o);

  a_r10_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r10_err_with_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> done_o);

  a_r10_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !eng_start_o && !eng_buf_we_o && !hbuf_we_o && !eng_buf_clr_o);
endmodule

bind aux_xfer_seq aux_xfer_seq_chk u_chk (.*);

// File: tb/tb_aux_xfer_seq.sv
`timescale 1ns/1ps
module tb_aux_xfer_seq;
  localparam int LEN_W = 9;
  localparam int IDX_W = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic             req = 1'b0, wr = 1'b0;
  logic [19:0]      addr = '0;
  logic [LEN_W-1:0] len = '0;
  logic             busy, done, err;
  logic [IDX_W-1:0] hidx;
  logic [7:0]       hrd, hwd;
  logic             hwe;
  logic [7:0]       a_lo, a_mid, cmd, bwd;
  logic [3:0]       a_hi, bidx;
  logic             bclr, bwe, start, rack, eack;
  logic [7:0]       hmem [256];
  logic [7:0]       ebuf [16];
  logic             en_q, rep_q, err_q, act;
  logic [3:0]       st_q;
  int               ecnt, cur_out;
  logic [19:0]      cur_addr;

  assign hrd = hmem[hidx];

  aux_xfer_seq #(.CLK_KHZ(2)) dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .wr_i(wr), .addr_i(addr), .len_i(len),
    .busy_o(busy), .done_o(done), .err_o(err),
    .hbuf_idx_o(hidx), .hbuf_rdata_i(hrd), .hbuf_we_o(hwe), .hbuf_wdata_o(hwd),
    .eng_addr_lo_o(a_lo), .eng_addr_mid_o(a_mid), .eng_addr_hi_o(a_hi), .eng_cmd_o(cmd),
    .eng_buf_clr_o(bclr), .eng_buf_we_o(bwe), .eng_buf_idx_o(bidx), .eng_buf_wdata_o(bwd),
    .eng_buf_rdata_i(ebuf[bidx]), .eng_start_o(start), .eng_en_i(en_q),
    .eng_reply_i(rep_q), .eng_reply_ack_o(rack), .eng_err_i(err_q), .eng_err_ack_o(eack),
    .eng_status_i(st_q)
  );

  function automatic logic [7:0] rd_pat(input logic [19:0] a);
    return (a[7:0] * 8'd5) ^ {a[19:16], a[11:8]} ^ 8'h3C;
  endfunction

  // engine model; outcome 0 ok, 1 err flag, 2 bad status, 3 enable stuck, 4 no reply
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 0; rep_q <= 0; err_q <= 0; st_q <= 0; act <= 0; ecnt <= 0; cur_addr <= '0;
      for (int k = 0; k < 16; k++) ebuf[k] <= 8'h00;
    end else begin
      if (bclr) begin
        for (int k = 0; k < 16; k++) ebuf[k] <= 8'h00;
        en_q <= 0; act <= 0;
      end
      if (bwe) ebuf[bidx] <= bwd;
      if (start) begin
        en_q <= 1; act <= 1; ecnt <= 0; st_q <= 0;
        cur_addr <= {a_hi, a_mid, a_lo};
      end else if (act) begin
        ecnt <= ecnt + 1;
        if (ecnt == 2 && cur_out != 3) en_q <= 0;
        if (ecnt == 6 && cur_out != 3 && cur_out != 4) begin
          rep_q <= 1; act <= 0;
          err_q <= (cur_out == 1);
          st_q  <= (cur_out == 2) ? 4'h1 : 4'h0;
          if (cmd[0]) for (int k = 0; k < 16; k++) ebuf[k] <= rd_pat(cur_addr + 20'(k));
        end
      end
      if (rack) rep_q <= 0;
      if (eack) err_q <= 0;
    end
  end

  int n_chk = 0, n_fail = 0;
  task automatic check(input bit ok, input string rq, input string msg);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: %s", rq, msg);
    end
  endtask

  // reference model
  int outq[$];
  int e_addr, e_off, e_rem, e_fails, e_starts, last_out, hw_cnt;
  bit e_err, e_wr;

  always @(negedge clk) begin
    if (rst_n && start) begin
      int n;
      logic [7:0] ecmd;
      n = (e_rem > 16) ? 16 : e_rem;
      e_starts++;
      cur_out = (outq.size() > 0) ? outq.pop_front() : 0;
      check(!e_err && e_rem > 0, "R2", $sformatf("unexpected start act=1 exp=0 rem=%0d", e_rem));
      check({a_hi, a_mid, a_lo} == 20'(e_addr), "R3",
            $sformatf("addr act=%h exp=%h", {a_hi, a_mid, a_lo}, 20'(e_addr)));
      ecmd = {4'(n - 1), 1'b1, 2'b00, !e_wr};
      check(cmd == ecmd, "R4", $sformatf("cmd act=%h exp=%h (R1 len %0d)", cmd, ecmd, n));
      if (e_wr)
        for (int k = 0; k < n; k++)
          check(ebuf[k] == hmem[e_off + k], "R5",
                $sformatf("wbuf[%0d] act=%h exp=%h", k, ebuf[k], hmem[e_off + k]));
      last_out = cur_out;
      if (cur_out == 0) begin
        e_addr = (e_addr + n) & 32'hFFFFF; e_off += n; e_rem -= n; e_fails = 0;
      end else begin
        e_fails++;
        if (e_fails == 10) e_err = 1;
      end
    end
    if (rst_n && hwe) begin
      hw_cnt++;
      check(last_out == 0 && !e_wr, "R9", $sformatf("host write after outcome act=%0d exp=0", last_out));
      hmem[hidx] = hwd;
    end
  end

  task automatic run(input bit w, input logic [19:0] a, input int l,
                     input int exp_starts, input bit inject);
    int cyc;
    e_addr = a; e_off = 0; e_rem = l; e_fails = 0; e_starts = 0; e_err = 0; e_wr = w;
    hw_cnt = 0; last_out = 0;
    for (int k = 0; k < 256; k++) hmem[k] = w ? 8'(k * 3 + 1) : 8'hEE;
    @(negedge clk);
    req = 1; wr = w; addr = a; len = LEN_W'(l);
    @(negedge clk);
    req = 0;
    if (l > 0) check(busy == 1, "R10", $sformatf("busy act=%0b exp=1", busy));
    cyc = 0;
    while (!done && cyc < 5000) begin
      if (inject && cyc == 8) begin req = 1; wr = 0; addr = 20'h00777; len = 1; end
      else req = 0;
      @(negedge clk);
      cyc++;
    end
    req = 0;
    check(done == 1, "R10", $sformatf("done act=%0b exp=1", done));
    check(err == e_err, "R2", $sformatf("err act=%0b exp=%0b", err, e_err));
    check(e_starts == exp_starts, "R1", $sformatf("starts act=%0d exp=%0d", e_starts, exp_starts));
    if (!e_err) check(e_rem == 0, "R1", $sformatf("remaining act=%0d exp=0", e_rem));
    if (!w) begin
      check(hw_cnt == e_off, "R9", $sformatf("host writes act=%0d exp=%0d", hw_cnt, e_off));
      for (int k = 0; k < e_off; k++)
        check(hmem[k] == rd_pat(a + 20'(k)), "R9",
              $sformatf("rdata[%0d] act=%h exp=%h", k, hmem[k], rd_pat(a + 20'(k))));
      if (e_off < 256) check(hmem[e_off] == 8'hEE, "R9",
              $sformatf("past end act=%h exp=ee", hmem[e_off]));
    end else check(hw_cnt == 0, "R9", $sformatf("host writes act=%0d exp=0", hw_cnt));
    @(negedge clk);
    check(done == 0, "R10", $sformatf("done width act=%0b exp=0", done));
    repeat (3) @(negedge clk);
    check(busy == 0 && e_starts == exp_starts, "R10",
          $sformatf("idle act busy=%0b starts=%0d exp 0/%0d", busy, e_starts, exp_starts));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(0, "WDOG", "watchdog act=expired exp=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(!busy && !done && !err && !start, "R10",
          $sformatf("reset act=%0b%0b%0b%0b exp=0000", busy, done, err, start));
    run(0, 20'h00100, 0, 0, 0);                    // R11 zero length
    run(1, 20'h12345, 5, 1, 0);                    // R1 R4 R5 single write chunk
    run(0, 20'hFFFF8, 37, 3, 0);                   // R1 R3 wrap, remainder chunk
    outq = '{1, 2, 0, 0};
    run(0, 20'h0A000, 32, 4, 0);                   // R8 err flag and bad status, R9
    outq = '{3, 4, 0, 0};
    run(1, 20'h30010, 20, 4, 0);                   // R6 enable timeout, R7 reply timeout
    outq = '{1, 1, 2, 2, 3, 4, 1, 2, 1, 2};
    run(0, 20'h45600, 3, 10, 0);                   // R2 ten failures
    outq = '{0, 1, 0};
    run(1, 20'h00050, 18, 3, 1);                   // R10 request ignored while busy
    run(0, 20'h7FFF0, 16, 1, 0);                   // R1 exact chunk
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule